// File: doc/BRIEF.md
# GPIO Port Controller with Edge Interrupts and Event Output

An 18-pin general-purpose I/O controller with one configuration bit per pin for each function. The functions are:

- **Ownership**: the pin belongs to the GPIO logic or is handed to a keypad scanner.
- **Direction**: the pin is an input or an output.
- **Output value**: a separate output data bit.
- **Debounce bypass**: skips the input filter.
- **Edge polarity**: selects which transition counts.
- **Interrupt enable**: lets a set status bit reach the interrupt line.
- **Event routing**: sends transitions to an event stream instead of the status register.

A host reaches all of this through a simple byte-wide register port. Reads return data one cycle later. Reading the interrupt status bank clears the bits that were returned.

Input pins pass through a two-stage synchroniser and then an optional debounce filter. The filter accepts a new level only after the synchronised input has differed from the accepted level for `DB_TICKS` consecutive slow ticks. Edges on the filtered level have two possible destinations. On an interrupt pin, an edge of the selected polarity sets a sticky status bit. On an event-routed pin, both edges produce a code on a valid/ready output stream, which feeds an external event queue.

The interrupt line is the OR of every status bit whose enable is set and whose pin is currently a GPIO input. The event output holds its code stable until `ev_ready` is seen high at a rising edge. While the output is blocked, further transitions on a pin merge into one pending entry that carries the pin's latest level. Pending pins are offered lowest pin number first.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Ownership bit 1 hands a pin to the keypad: `kp_sel` mirrors the ownership bits, and that pin never drives, sets status or produces events. Bit 0 makes it GPIO.
- R2: `pin_oe` is high exactly for GPIO pins whose direction bit is 1; direction 0 makes the pin an input.
- R3: The output data bits appear on `pin_out` whatever the direction, so a value can be loaded before the pin is turned into an output. Writing them changes nothing read back for an input pin.
- R4: The pin-state bank returns the output data bit for GPIO outputs and the filtered input level for all other pins.
- R5: For a GPIO input that is not event-routed, polarity bit 0 sets the status bit on a high-to-low filtered transition and 1 sets it on a low-to-high transition. The opposite edge sets nothing.
- R6: Reading a status bank returns its bits and clears them in the same cycle; later qualifying edges set them again.
- R7: `irq` is high when some status bit is set, its enable bit is 1 and its pin is a GPIO input. Turning that pin into an output removes its contribution.
- R8: An event-routed GPIO input emits a code on both edges: bit 5 is the new level and bits 4:0 are the pin number. It never sets a status bit.
- R9: `ev_valid` and `ev_code` hold until accepted by `ev_ready` at a rising edge. Pending pins go out lowest number first. Repeated transitions while a pin is pending merge into one code with the latest level.
- R10: Debounce bypass bit 1 passes the synchronised input straight through. Bit 0 accepts a new level only after it has been held for `DB_TICKS` ticks, so shorter pulses are lost.
- R11: `reg_addr[5:2]` selects the function:

  | Code | Function |
  |------|----------|
  | 0 | ownership |
  | 1 | direction |
  | 2 | output data |
  | 3 | pin state |
  | 4 | interrupt enable |
  | 5 | polarity |
  | 6 | event routing |
  | 7 | debounce bypass |
  | 8 | status |

  `reg_addr[1:0]` selects the bank: bank 0 holds pins 0–7, bank 1 pins 8–15 and bank 2 pins 16–17 in bits 1:0. Unused bits and bank 3 read 0. Writes to the pin-state and status banks are ignored.
- R12: After reset every configuration and status bit is 0, `irq` is 0 and `ev_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Function code and bank |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; data valid next cycle |
| reg_rdata | output | 8 | Read data, held until the next read |
| tick | input | 1 | Slow debounce tick strobe |
| pin_in | input | 18 | Pad input levels |
| pin_out | output | 18 | Output data bits |
| pin_oe | output | 18 | Output enables |
| kp_sel | output | 18 | Pins handed to the keypad scanner |
| irq | output | 1 | Combined interrupt |
| ev_valid | output | 1 | Event code valid |
| ev_ready | input | 1 | Event sink ready |
| ev_code | output | 6 | {level, pin number} |

## Verification
Single pins are toggled in both directions under both polarity settings. This separates rising from falling qualification and shows that a clear-on-read does not lose a later edge. Input and output directions are swapped while output data is preloaded, which tells a held output value apart from a driven pin and from an interrupt contribution. Two event pins change in the same cycle with the sink stalled, and one of them changes again before release. The accepted order and codes then separate priority, hold stability and merging. A debounced pin receives a pulse shorter than the filter window and then a long level, which tells rejection from acceptance.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int FN_W   = 4;
  localparam int BANK_W = 2;
  localparam int ADDR_W = FN_W + BANK_W;
  localparam int PADW   = (1 << BANK_W) * 8;

  localparam logic [FN_W-1:0] FN_MODE  = 4'd0;
  localparam logic [FN_W-1:0] FN_DIR   = 4'd1;
  localparam logic [FN_W-1:0] FN_DOUT  = 4'd2;
  localparam logic [FN_W-1:0] FN_DATA  = 4'd3;
  localparam logic [FN_W-1:0] FN_IEN   = 4'd4;
  localparam logic [FN_W-1:0] FN_POL   = 4'd5;
  localparam logic [FN_W-1:0] FN_EVM   = 4'd6;
  localparam logic [FN_W-1:0] FN_DBDIS = 4'd7;
  localparam logic [FN_W-1:0] FN_STAT  = 4'd8;
endpackage

// File: rtl/gpio_cfg_regs.sv
`timescale 1ns/1ps
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  input  logic [NPIN-1:0]   pin_state,
  input  logic [NPIN-1:0]   stat_set,
  output logic [NPIN-1:0]   mode,
  output logic [NPIN-1:0]   dir,
  output logic [NPIN-1:0]   dout,
  output logic [NPIN-1:0]   ien,
  output logic [NPIN-1:0]   pol,
  output logic [NPIN-1:0]   evm,
  output logic [NPIN-1:0]   dbdis,
  output logic [NPIN-1:0]   stat
);
  localparam int NCFG = 8;

  logic [FN_W-1:0]   fn;
  logic [BANK_W-1:0] bank;
  logic [NPIN-1:0]   bank_mask, wr_vec, clr_mask, rd_vec;
  logic [NPIN-1:0]   cfg_q [NCFG];
  logic [NPIN-1:0]   stat_q;
  logic [PADW-1:0]   rd_pad;

  assign fn   = reg_addr[ADDR_W-1:BANK_W];
  assign bank = reg_addr[BANK_W-1:0];

  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      bank_mask[p] = (bank == BANK_W'(p / 8));
      wr_vec[p]    = reg_wdata[p % 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NCFG; f++) cfg_q[f] <= '0;
    end else if (reg_wr && fn < FN_W'(NCFG) && fn != FN_DATA) begin
      cfg_q[fn[2:0]] <= (cfg_q[fn[2:0]] & ~bank_mask) | (wr_vec & bank_mask);
    end
  end

  assign clr_mask = (reg_rd && fn == FN_STAT) ? bank_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | stat_set;
  end

  always_comb begin
    case (fn)
      FN_DATA: rd_vec = pin_state;
      FN_STAT: rd_vec = stat_q;
      default: rd_vec = (fn < FN_W'(NCFG)) ? cfg_q[fn[2:0]] : '0;
    endcase
    rd_pad = {{(PADW-NPIN){1'b0}}, rd_vec};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_pad[bank*8 +: 8];
  end

  assign mode  = cfg_q[FN_MODE[2:0]];
  assign dir   = cfg_q[FN_DIR[2:0]];
  assign dout  = cfg_q[FN_DOUT[2:0]];
  assign ien   = cfg_q[FN_IEN[2:0]];
  assign pol   = cfg_q[FN_POL[2:0]];
  assign evm   = cfg_q[FN_EVM[2:0]];
  assign dbdis = cfg_q[FN_DBDIS[2:0]];
  assign stat  = stat_q;

  AST_STAT_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(stat_set)) == '0)); // R5
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && fn == FN_STAT) |=> ((stat_q & $past(bank_mask) & ~$past(stat_set)) == '0)); // R6
  AST_RDATA_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && bank == BANK_W'(3)) |=> (reg_rdata == 8'h00)); // R11
endmodule

// File: rtl/gpio_in_filter.sv
`timescale 1ns/1ps
module gpio_in_filter #(
  parameter int NPIN     = 18,
  parameter int DB_TICKS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] dbdis,
  output logic [NPIN-1:0] level
);
  localparam int CNT_W = $clog2(DB_TICKS + 1);

  logic [NPIN-1:0]  s1, s2, filt;
  logic [CNT_W-1:0] cnt [NPIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        filt[g] <= 1'b0;
        cnt[g]  <= '0;
      end else if (dbdis[g]) begin
        filt[g] <= s2[g];
        cnt[g]  <= '0;
      end else if (s2[g] == filt[g]) begin
        cnt[g]  <= '0;
      end else if (tick) begin
        if (cnt[g] == CNT_W'(DB_TICKS - 1)) begin
          filt[g] <= s2[g];
          cnt[g]  <= '0;
        end else begin
          cnt[g]  <= cnt[g] + 1'b1;
        end
      end
    end

    AST_DB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbdis[g] && $past(!dbdis[g]) && filt[g] != $past(filt[g])) |-> ($past(s2[g]) == filt[g])); // R10
  end

  assign level = filt;
endmodule

// File: rtl/gpio_edge_detect.sv
`timescale 1ns/1ps
module gpio_edge_detect #(
  parameter int NPIN = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] level,
  input  logic [NPIN-1:0] mode,
  input  logic [NPIN-1:0] dir,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] evm,
  output logic [NPIN-1:0] stat_set,
  output logic [NPIN-1:0] ev_req
);
  logic [NPIN-1:0] level_q, rise, fall, is_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level;
  end

  assign rise     = level & ~level_q;
  assign fall     = ~level & level_q;
  assign is_in    = ~mode & ~dir;
  assign stat_set = ((pol & rise) | (~pol & fall)) & is_in & ~evm;
  assign ev_req   = (rise | fall) & is_in & evm;

  AST_EV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_req != '0) |-> ((ev_req & $past(~evm)) == '0 || $changed(evm))); // R8
endmodule

// File: rtl/gpio_event_arb.sv
`timescale 1ns/1ps
module gpio_event_arb #(
  parameter int NPIN  = 18,
  parameter int PIN_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] ev_req,
  input  logic [NPIN-1:0] level,
  input  logic            ev_ready,
  output logic            ev_valid,
  output logic [PIN_W:0]  ev_code
);
  logic [NPIN-1:0]  pend_q, lvl_q, take;
  logic             pick_any, load, out_valid_q;
  logic [PIN_W-1:0] pick_idx;
  logic [PIN_W:0]   out_code_q;

  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    for (int p = NPIN - 1; p >= 0; p--) begin
      if (pend_q[p]) begin
        pick_any = 1'b1;
        pick_idx = PIN_W'(p);
      end
    end
  end

  assign load = pick_any && (!out_valid_q || ev_ready);
  assign take = load ? ({{(NPIN-1){1'b0}}, 1'b1} << pick_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      lvl_q       <= '0;
      out_valid_q <= 1'b0;
      out_code_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~take) | ev_req;
      for (int p = 0; p < NPIN; p++)
        if (ev_req[p]) lvl_q[p] <= level[p];
      if (load) begin
        out_valid_q <= 1'b1;
        out_code_q  <= {lvl_q[pick_idx], pick_idx};
      end else if (ev_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign ev_valid = out_valid_q;
  assign ev_code  = out_code_q;

  AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_code))); // R9
  AST_EV_PIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (int'(ev_code[PIN_W-1:0]) < NPIN)); // R8
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN     = 18,
  parameter int DB_TICKS = 4,
  localparam int PIN_W   = $clog2(NPIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  input  logic              tick,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   kp_sel,
  output logic              irq,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [PIN_W:0]    ev_code
);
  logic [NPIN-1:0] mode, dir, dout, ien, pol, evm, dbdis, stat;
  logic [NPIN-1:0] level, stat_set, ev_req, is_out, is_in, pin_state;

  assign is_out    = ~mode & dir;
  assign is_in     = ~mode & ~dir;
  assign pin_state = (is_out & dout) | (~is_out & level);

  gpio_cfg_regs #(.NPIN(NPIN)) u_regs (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rd, .reg_rdata,
    .pin_state, .stat_set,
    .mode, .dir, .dout, .ien, .pol, .evm, .dbdis, .stat
  );

  gpio_in_filter #(.NPIN(NPIN), .DB_TICKS(DB_TICKS)) u_filter (
    .clk, .rst_n, .tick, .pin_in, .dbdis, .level
  );

  gpio_edge_detect #(.NPIN(NPIN)) u_edge (
    .clk, .rst_n, .level, .mode, .dir, .pol, .evm, .stat_set, .ev_req
  );

  gpio_event_arb #(.NPIN(NPIN), .PIN_W(PIN_W)) u_arb (
    .clk, .rst_n, .ev_req, .level, .ev_ready, .ev_valid, .ev_code
  );

  assign pin_out = dout;
  assign pin_oe  = is_out;
  assign kp_sel  = mode;
  assign irq     = |(stat & ien & is_in);

  AST_KP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & $past(mode)) == '0)); // R1
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  localparam int NPIN = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        tick = 1'b0;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out, pin_oe, kp_sel;
  logic        irq, ev_valid;
  logic        ev_ready = 1'b1;
  logic [5:0]  ev_code;

  int vec_cnt = 0, err_cnt = 0;
  logic [5:0] exp_q[$];
  logic [7:0] rv;
  int tick_div = 0;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rd, .reg_rdata, .tick,
    .pin_in, .pin_out, .pin_oe, .kp_sel, .irq, .ev_valid, .ev_ready, .ev_code
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tick_div <= (tick_div + 1) % 4;
    tick     <= (tick_div == 3);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] fn, input logic [1:0] bank, input logic [7:0] d);
    @(negedge clk);
    reg_addr = {fn, bank}; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] fn, input logic [1:0] bank, output logic [7:0] d);
    @(negedge clk);
    reg_addr = {fn, bank}; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic expect_ev(input logic [5:0] c);
    exp_q.push_back(c);
  endtask

  // Scoreboard monitor: every accepted event is compared with the queue head.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && ev_valid && ev_ready) begin
        if (exp_q.size() == 0) begin
          vec_cnt++; err_cnt++;
          $display("FAIL R9: unexpected event actual %0h expected none", ev_code);
        end else begin
          check("R8 event code", {26'd0, ev_code}, {26'd0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    // R12 reset state
    rd(4'd0, 2'd0, rv); check("R12 mode reset", {24'd0, rv}, 32'h00);
    check("R12 irq", {31'd0, irq}, 32'd0);
    check("R12 ev_valid", {31'd0, ev_valid}, 32'd0);
    check("R12 pin_oe", {14'd0, pin_oe}, 32'd0);

    wr(4'd7, 2'd0, 8'hFF); wr(4'd7, 2'd1, 8'hFF); wr(4'd7, 2'd2, 8'h03);

    // R11 address map, padding, ignored writes
    wr(4'd0, 2'd2, 8'hFF);
    rd(4'd0, 2'd2, rv); check("R11 bank2 pad", {24'd0, rv}, 32'h03);
    check("R1 kp_sel mirrors", {30'd0, kp_sel[17:16]}, 32'h3);
    wr(4'd0, 2'd3, 8'hFF);
    rd(4'd0, 2'd3, rv); check("R11 bank3 zero", {24'd0, rv}, 32'h00);
    wr(4'd0, 2'd2, 8'h00);
    wr(4'd8, 2'd1, 8'hFF);
    rd(4'd8, 2'd1, rv); check("R11 status write ignored", {24'd0, rv}, 32'h00);

    // R1 keypad pin produces no status
    wr(4'd0, 2'd0, 8'h01); wr(4'd5, 2'd0, 8'h01);
    pin_in[0] = 1'b1; wait_clk(10);
    rd(4'd8, 2'd0, rv); check("R1 keypad pin no status", {24'd0, rv}, 32'h00);
    pin_in[0] = 1'b0; wait_clk(10);
    wr(4'd0, 2'd0, 8'h00); wr(4'd5, 2'd0, 8'h00);

    // R2 R3 R4 direction and output data
    wr(4'd2, 2'd0, 8'hA5);
    check("R3 pin_out preloaded", {24'd0, pin_out[7:0]}, 32'hA5);
    check("R2 input not driven", {24'd0, pin_oe[7:0]}, 32'h00);
    rd(4'd3, 2'd0, rv); check("R3 dout no effect on inputs", {24'd0, rv}, 32'h00);
    wr(4'd1, 2'd0, 8'hFF);
    check("R2 output enabled", {24'd0, pin_oe[7:0]}, 32'hFF);
    rd(4'd3, 2'd0, rv); check("R4 outputs read dout", {24'd0, rv}, 32'hA5);
    wr(4'd1, 2'd0, 8'h00);
    pin_in[3] = 1'b1; wait_clk(10);
    rd(4'd3, 2'd0, rv); check("R4 inputs read level", {24'd0, rv}, 32'h08);
    pin_in[3] = 1'b0; wait_clk(10);
    rd(4'd8, 2'd0, rv); check("R5 falling default", {24'd0, rv}, 32'h08);

    // R5 R6 polarity and clear-on-read
    wr(4'd5, 2'd1, 8'h01);
    pin_in[8] = 1'b1; wait_clk(10);
    rd(4'd8, 2'd1, rv); check("R5 rising pin8", {24'd0, rv}, 32'h01);
    rd(4'd8, 2'd1, rv); check("R6 cleared on read", {24'd0, rv}, 32'h00);
    pin_in[9] = 1'b1; wait_clk(10);
    pin_in[9] = 1'b0; wait_clk(10);
    pin_in[8] = 1'b0; wait_clk(10);
    rd(4'd8, 2'd1, rv); check("R5 edge selectivity", {24'd0, rv}, 32'h02);

    // R7 interrupt line
    wr(4'd4, 2'd1, 8'h02);
    check("R7 irq idle", {31'd0, irq}, 32'd0);
    pin_in[9] = 1'b1; wait_clk(10);
    pin_in[9] = 1'b0; wait_clk(10);
    check("R7 irq raised", {31'd0, irq}, 32'd1);
    rd(4'd8, 2'd1, rv); check("R6 read returns bit", {24'd0, rv}, 32'h02);
    check("R7 irq drops after read", {31'd0, irq}, 32'd0);
    pin_in[8] = 1'b1; wait_clk(10);
    wr(4'd4, 2'd1, 8'h01);
    check("R7 irq pin8", {31'd0, irq}, 32'd1);
    wr(4'd1, 2'd1, 8'h01);
    check("R7 output pin masked", {31'd0, irq}, 32'd0);
    wr(4'd1, 2'd1, 8'h00);
    check("R7 input again", {31'd0, irq}, 32'd1);
    rd(4'd8, 2'd1, rv); check("R6 pin8 read", {24'd0, rv}, 32'h01);
    wr(4'd4, 2'd1, 8'h00);
    pin_in[8] = 1'b0; wait_clk(10);

    // R8 event routing
    wr(4'd6, 2'd2, 8'h03);
    expect_ev(6'h30); pin_in[16] = 1'b1; wait_clk(10);
    expect_ev(6'h10); pin_in[16] = 1'b0; wait_clk(10);
    rd(4'd8, 2'd2, rv); check("R8 no status for events", {24'd0, rv}, 32'h00);
    check("R8 queue drained", exp_q.size(), 32'd0);

    // R9 back-pressure, priority, merging
    @(negedge clk); ev_ready = 1'b0;
    expect_ev(6'h30); expect_ev(6'h11);
    pin_in[16] = 1'b1; pin_in[17] = 1'b1; wait_clk(10);
    check("R9 valid held", {31'd0, ev_valid}, 32'd1);
    check("R9 lowest first", {26'd0, ev_code}, 32'h30);
    pin_in[17] = 1'b0; wait_clk(10);
    check("R9 code stable", {26'd0, ev_code}, 32'h30);
    ev_ready = 1'b1; wait_clk(10);
    check("R9 merged drain", exp_q.size(), 32'd0);

    // R10 debounce
    wr(4'd7, 2'd0, 8'hFD); wr(4'd5, 2'd0, 8'h02);
    pin_in[1] = 1'b1; wait_clk(6);
    pin_in[1] = 1'b0; wait_clk(20);
    rd(4'd3, 2'd0, rv); check("R10 short pulse rejected", {24'd0, rv}, 32'h00);
    rd(4'd8, 2'd0, rv); check("R10 no status on glitch", {24'd0, rv}, 32'h00);
    pin_in[1] = 1'b1; wait_clk(40);
    rd(4'd3, 2'd0, rv); check("R10 long level accepted", {24'd0, rv}, 32'h02);
    rd(4'd8, 2'd0, rv); check("R10 status after debounce", {24'd0, rv}, 32'h02);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule